// File: doc/BRIEF.md
# Fine-Grain Multithread Issue Selector

This block decides, on every clock cycle, which of several hardware threads sharing one single-issue in-order pipeline gets the issue slot. Threads are interleaved cycle by cycle: each cycle at most one thread is granted, and among the threads able to issue, the one granted longest ago wins.

Each thread carries a small state machine with three states: ready, pending (a long-latency operation such as a load, branch, multiply or divide is outstanding) and halted (a cache miss, trap or resource conflict has stopped it). Event pulses from the pipeline move threads between these states. The states take effect in the following cycle. A per-cycle enable input can also mask a thread without changing its state. The block keeps a recency list of thread numbers, with the least recently granted thread at the front. The list is updated only when a grant is made.

The grant outputs are combinational from the registered thread states, the registered recency list and the enable input of the current cycle. The pipeline samples them at the clock edge, and that same edge commits the recency update.

Top module: `mt_issue_sel`

## Requirements
- R1: At most one bit of `grant_oh` is set in any cycle, and when one is set, `grant_id` gives its index.
- R2: `grant_valid` is 1 exactly when some thread is eligible. A thread is eligible when its enable bit is set and its state is ready. With no eligible thread, `grant_oh` is all zeros.
- R3: When several threads are eligible, the grant goes to the one that sits earliest in the recency list, which is the one granted least recently.
- R4: After reset the recency list is 0,1,2,3 from highest to lowest priority, so with all threads eligible the first grant goes to thread 0. All threads leave reset in the ready state.
- R5: A granted thread moves to the last (lowest-priority) place in the list. The threads behind it each move up one place.
- R6: In a cycle with no grant, the recency list is left unchanged.
- R7: A `halt_ev` pulse on a thread puts it in the halted state from the next cycle, whatever state it was in. It stays ineligible until a resume pulse arrives.
- R8: If `halt_ev` and `resume_ev` reach the same thread in the same cycle, the halt takes effect and the resume is ignored.
- R9: A `resume_ev` pulse on a halted thread makes it ready, and so eligible, in the next cycle.
- R10: A `lat_start` pulse on a ready thread puts it in the pending state from the next cycle. It stays ineligible until a `lat_done` pulse, and becomes ready in the cycle after that pulse.
- R11: Clearing a thread's `thr_en` bit removes it from selection in that cycle only. Its state and its place in the list are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | NUM_THREADS | Per-cycle enable for each thread |
| halt_ev | input | NUM_THREADS | Halt pulse (miss, trap, conflict) per thread |
| resume_ev | input | NUM_THREADS | Resume pulse for a halted thread |
| lat_start | input | NUM_THREADS | Long-latency operation started |
| lat_done | input | NUM_THREADS | Long-latency operation completed |
| grant_oh | output | NUM_THREADS | One-hot issue grant |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_id | output | $clog2(NUM_THREADS) | Index of the granted thread |

## Verification
If the recency list were corrupted, the order of grants would differ from the model's. With all threads enabled, this shows up within one rotation of at most four cycles. A thread state machine stuck in the wrong state shows up as a missing or extra grant in the first cycle that the thread is the only one enabled. The bench therefore keeps its own model of the states and the list. It compares every grant against the model over directed event sequences and a long pseudo-random sweep of enables and event pulses.

// File: rtl/mtsel_pkg.sv
package mtsel_pkg;
    typedef enum logic [1:0] {
        TS_READY   = 2'd0,
        TS_PENDING = 2'd1,
        TS_HALTED  = 2'd2
    } thr_state_e;
endpackage

// File: rtl/mtsel_thread_fsm.sv
module mtsel_thread_fsm
    import mtsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_ev,
    input  logic resume_ev,
    input  logic lat_start,
    input  logic lat_done,
    output logic ready
);
    typedef struct packed {
        thr_state_e state;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (halt_ev) begin
            r_d.state = TS_HALTED;                 // halt dominates (R7, R8)
        end else begin
            unique case (r_q.state)
                TS_HALTED:  if (resume_ev) r_d.state = TS_READY;
                TS_PENDING: if (lat_done)  r_d.state = TS_READY;
                TS_READY:   if (lat_start) r_d.state = TS_PENDING;
                default:    r_d.state = TS_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: TS_READY};
        else        r_q <= r_d;
    end

    assign ready = (r_q.state == TS_READY);

    assert_halt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_ev && resume_ev) |=> (r_q.state == TS_HALTED));
    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ev |=> !ready);
    assert_resume_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_ev && resume_ev && r_q.state == TS_HALTED) |=> ready);
    assert_pending_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == TS_PENDING && !lat_done && !halt_ev) |=> (r_q.state == TS_PENDING));
endmodule

// File: rtl/mtsel_lru_order.sv
module mtsel_lru_order #(
    parameter int NUM_THREADS = 4,
    localparam int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] eligible,
    output logic                   pick_valid,
    output logic [IDW-1:0]         pick_id
);
    typedef struct packed {
        logic [NUM_THREADS-1:0][IDW-1:0] order;   // order[0] = least recent
    } lru_regs_t;

    lru_regs_t r_d, r_q;
    logic [IDW-1:0] pos;
    logic [NUM_THREADS-1:0] seen;

    always_comb begin
        pick_valid = 1'b0;
        pos        = '0;
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            if (eligible[r_q.order[k]]) begin
                pick_valid = 1'b1;
                pos        = IDW'(k);
            end
        end
        pick_id = r_q.order[pos];

        r_d = r_q;
        if (pick_valid) begin
            for (int k = 0; k < NUM_THREADS; k++) begin
                if (k >= int'(pos)) begin
                    if (k == NUM_THREADS - 1) r_d.order[k] = pick_id;
                    else                      r_d.order[k] = r_q.order[k+1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_THREADS; k++) r_q.order[k] <= IDW'(k);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        seen = '0;
        for (int k = 0; k < NUM_THREADS; k++) seen[r_q.order[k]] = 1'b1;
    end

    assert_order_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {NUM_THREADS{1'b1}});
    assert_granted_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |=> (r_q.order[NUM_THREADS-1] == $past(pick_id)));
    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |=> $stable(r_q.order));
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel #(
    parameter int NUM_THREADS = 4,
    localparam int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_en,
    input  logic [NUM_THREADS-1:0] halt_ev,
    input  logic [NUM_THREADS-1:0] resume_ev,
    input  logic [NUM_THREADS-1:0] lat_start,
    input  logic [NUM_THREADS-1:0] lat_done,
    output logic [NUM_THREADS-1:0] grant_oh,
    output logic                   grant_valid,
    output logic [IDW-1:0]         grant_id
);
    logic [NUM_THREADS-1:0] thr_ready;
    logic [NUM_THREADS-1:0] eligible;
    logic                   pick_valid;
    logic [IDW-1:0]         pick_id;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        mtsel_thread_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .halt_ev   (halt_ev[t]),
            .resume_ev (resume_ev[t]),
            .lat_start (lat_start[t]),
            .lat_done  (lat_done[t]),
            .ready     (thr_ready[t])
        );
    end

    assign eligible = thr_ready & thr_en;

    mtsel_lru_order #(.NUM_THREADS(NUM_THREADS)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .pick_valid (pick_valid),
        .pick_id    (pick_id)
    );

    always_comb begin
        grant_oh = '0;
        if (pick_valid) grant_oh[pick_id] = 1'b1;
        grant_valid = pick_valid;
        grant_id    = pick_id;
    end

    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh));
    assert_grant_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> thr_en[grant_id]);
    assert_grant_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> thr_ready[grant_id]);
    assert_no_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(thr_en & thr_ready)) |-> grant_valid);
endmodule

// File: tb/mt_issue_sel_tb_top.sv
module mt_issue_sel_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] thr_en, halt_ev, resume_ev, lat_start, lat_done;
    logic [N-1:0] grant_oh;
    logic         grant_valid;
    logic [1:0]   grant_id;

    int checks = 0;
    int errors = 0;
    int st[N];      // 0 ready, 1 pending, 2 halted
    int ord[N];     // ord[0] = least recently granted
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    mt_issue_sel #(.NUM_THREADS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .halt_ev(halt_ev),
        .resume_ev(resume_ev), .lat_start(lat_start), .lat_done(lat_done),
        .grant_oh(grant_oh), .grant_valid(grant_valid), .grant_id(grant_id)
    );

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin st[i] = 0; ord[i] = i; end
    endtask

    // drive one cycle, compare against the model, then advance the model
    task automatic step(input logic [N-1:0] en, input logic [N-1:0] h,
                        input logic [N-1:0] r, input logic [N-1:0] ls,
                        input logic [N-1:0] ld, input string tag);
        int pick;
        int pos;
        logic [N-1:0] exp_oh;
        @(negedge clk);
        thr_en = en; halt_ev = h; resume_ev = r; lat_start = ls; lat_done = ld;
        #3;
        pick = -1; pos = -1;
        for (int k = N - 1; k >= 0; k--)
            if (en[ord[k]] && st[ord[k]] == 0) begin pick = ord[k]; pos = k; end
        exp_oh = '0;
        if (pick >= 0) exp_oh[pick] = 1'b1;
        chk(grant_valid == (pick >= 0), {tag, " valid"}, int'(grant_valid), int'(pick >= 0));
        chk(grant_oh == exp_oh, {tag, " grant"}, int'(grant_oh), int'(exp_oh));
        if (pick >= 0)
            chk(int'(grant_id) == pick, {tag, " id R1"}, int'(grant_id), pick);
        if (pick >= 0) begin
            for (int k = pos; k < N - 1; k++) ord[k] = ord[k+1];
            ord[N-1] = pick;
        end
        for (int i = 0; i < N; i++) begin
            if (h[i]) st[i] = 2;
            else if (st[i] == 2 && r[i]) st[i] = 0;
            else if (st[i] == 1 && ld[i]) st[i] = 0;
            else if (st[i] == 0 && ls[i]) st[i] = 1;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        thr_en = '0; halt_ev = '0; resume_ev = '0; lat_start = '0; lat_done = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_reset();

        // R2: nothing enabled gives no grant; R4: reset order starts at thread 0
        step(4'b0000, 0, 0, 0, 0, "R2 none enabled");
        step(4'b1111, 0, 0, 0, 0, "R4 first grant");
        // R3 and R5: rotation through all threads
        for (int c = 0; c < 6; c++) step(4'b1111, 0, 0, 0, 0, "R5 rotation");
        // R6: idle cycle keeps the list
        step(4'b0000, 0, 0, 0, 0, "R6 idle");
        step(4'b1111, 0, 0, 0, 0, "R6 after idle");
        // R11: masking keeps the thread's place
        step(4'b1110, 0, 0, 0, 0, "R11 masked");
        step(4'b0001, 0, 0, 0, 0, "R11 unmasked");
        // R8: halt and resume together on thread 1
        step(4'b0000, 4'b0010, 4'b0010, 0, 0, "R8 same cycle");
        step(4'b0010, 0, 0, 0, 0, "R8 still halted");
        step(4'b0010, 0, 4'b0010, 0, 0, "R7 halted until resume");
        step(4'b0010, 0, 0, 0, 0, "R9 eligible after resume");
        // R10: long-latency pending on thread 2
        step(4'b0000, 0, 0, 4'b0100, 0, "R10 start");
        step(4'b0100, 0, 0, 0, 0, "R10 pending");
        step(4'b0100, 0, 0, 0, 4'b0100, "R10 done pulse");
        step(4'b0100, 0, 0, 0, 0, "R10 ready again");
        // R7: halt while pending
        step(4'b0000, 0, 0, 4'b1000, 0, "R7 start pending");
        step(4'b0000, 4'b1000, 0, 0, 4'b1000, "R7 halt over done");
        step(4'b1000, 0, 0, 0, 0, "R7 halted");
        step(4'b1000, 0, 4'b1000, 0, 0, "R7 resume");
        step(4'b1000, 0, 0, 0, 0, "R9 back");
        // sweep over every enable pattern with all threads ready (R3)
        for (int m = 0; m < 16; m++)
            for (int c = 0; c < 3; c++) step(4'(m), 0, 0, 0, 0, "R3 enable sweep");
        // pseudo-random sweep of events
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] a;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            a = rng;
            step(a[3:0] | a[7:4], a[11:8] & a[15:12] & a[19:16],
                 a[23:20], a[27:24] & a[31:28], a[15:12] | a[23:20], "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule